// File: doc/BRIEF.md
# Raster Scan Timing Generator with Frame Counter

This block produces the horizontal and vertical scan timing for a parallel RGB display link. Software programs the active size, the two porches and the sync pulse width for each axis. Each field holds the wanted count minus one. Once enabled, the block walks every line through sync, back porch, active and front porch, and walks every frame through the same four phases, counted in lines. It drives sync pulses, a data-enable strobe and the pixel coordinates of the active area. It also reports the current vertical phase as a two-bit code.

A free-running frame identifier counts frame boundaries. In video mode the count advances when vertical sync starts. In command mode, where transfers follow a tearing-effect trigger, it advances when the vertical back porch starts. A one-cycle frame interrupt fires at the start of the vertical front porch and is latched in a pending flag that a one-cycle clear input resets. Interlaced output toggles a field flag at every field boundary. The timing fields and both mode selects are captured only at frame start, so software can rewrite them at any time.

Top module: `video_scan_timer`

## Requirements
- R1: After reset, and in every cycle the block is idle (enable low or software reset), hsync, vsync, de, frm_irq and field are 0, pix_x and pix_y are 0 and vphase is 0. Reset also clears frame_id and irq_pend.
- R2: While running, each line is (h_sync_m1+1) sync cycles, then (h_back_m1+1) back-porch cycles, then (h_act_m1+1) active cycles, then (h_front_m1+1) front-porch cycles. hsync is 1 exactly in the sync cycles.
- R3: A frame is (v_sync_m1+1) sync lines, (v_back_m1+1) back-porch lines, (v_act_m1+1) active lines and (v_front_m1+1) front-porch lines, in that order. vsync is 1 on the sync lines. The scan starts at the first hsync cycle of the first vsync line, one cycle after enable is sampled high.
- R4: de is 1 only when both the horizontal and the vertical phase are active. pix_x and pix_y count from 0 within the active area and are 0 elsewhere.
- R5: vphase encodes the vertical phase as 0 for sync, 1 for back porch, 2 for active and 3 for front porch.
- R6: With cmd_mode low, frame_id increments by one in the first cycle of vertical sync, including the first frame after enable.
- R7: With cmd_mode high, frame_id increments by one in the first cycle of the vertical back porch and does not change at vertical sync.
- R8: frame_id only ever steps up by one, wraps modulo 2^FW, and is cleared to 0 by sw_rst. sw_rst also stops the scan and clears irq_pend.
- R9: frm_irq is a one-cycle pulse in the first cycle of the vertical front porch. irq_pend is set in that cycle and holds until a cycle with irq_clr high. A set in the same cycle as a clear wins.
- R10: With ilace_en sampled high at a frame boundary, field toggles at that boundary. Otherwise field is 0. Each field scans the programmed line counts.
- R11: All timing fields, cmd_mode and ilace_en are sampled only at frame start. A change during a frame takes effect from the next frame.
- R12: Dropping enable stops the scan in the next cycle. Raising it again restarts from the first cycle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous software reset: stops the scan, clears the counter and pending flag |
| en | input | 1 | Run enable |
| cmd_mode | input | 1 | 1: counter advances at vertical back porch; 0: at vertical sync |
| ilace_en | input | 1 | Interlaced output select |
| h_sync_m1 | input | HW | Hsync width minus one |
| h_back_m1 | input | HW | Horizontal back porch minus one |
| h_act_m1 | input | HW | Active pixels per line minus one |
| h_front_m1 | input | HW | Horizontal front porch minus one |
| v_sync_m1 | input | VW | Vsync width in lines minus one |
| v_back_m1 | input | VW | Vertical back porch minus one |
| v_act_m1 | input | VW | Active lines per field minus one |
| v_front_m1 | input | VW | Vertical front porch minus one |
| irq_clr | input | 1 | Clears irq_pend (write-one pulse) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pix_x | output | HW | Active pixel column |
| pix_y | output | VW | Active line |
| vphase | output | 2 | Vertical phase code |
| field | output | 1 | Interlace field flag |
| frame_id | output | FW | Frame counter |
| frm_irq | output | 1 | Frame interrupt pulse |
| irq_pend | output | 1 | Sticky pending interrupt |

## Verification
The assertions assume the timing fields describe a frame with at least three lines before the front porch, which the encoding guarantees. They also assume sw_rst and irq_clr are synchronous pulses that take effect on the next edge. The stimulus changes inputs only on the falling clock edge. It uses short lines and frames so that many frame boundaries, mode changes and a counter wrap fit into a short run. It rewrites timing fields only in the middle of a frame, which exercises the sampling rule.

// File: rtl/video_scan_timer.sv
module video_scan_timer #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          en,
  input  logic          cmd_mode,
  input  logic          ilace_en,
  input  logic [HW-1:0] h_sync_m1,
  input  logic [HW-1:0] h_back_m1,
  input  logic [HW-1:0] h_act_m1,
  input  logic [HW-1:0] h_front_m1,
  input  logic [VW-1:0] v_sync_m1,
  input  logic [VW-1:0] v_back_m1,
  input  logic [VW-1:0] v_act_m1,
  input  logic [VW-1:0] v_front_m1,
  input  logic          irq_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y,
  output logic [1:0]    vphase,
  output logic          field,
  output logic [FW-1:0] frame_id,
  output logic          frm_irq,
  output logic          irq_pend
);

  localparam logic [1:0] PH_SYNC  = 2'd0;
  localparam logic [1:0] PH_BACK  = 2'd1;
  localparam logic [1:0] PH_ACT   = 2'd2;
  localparam logic [1:0] PH_FRONT = 2'd3;

  logic          run;
  logic [1:0]    hph, vph;
  logic [HW-1:0] hcnt, hlim;
  logic [VW-1:0] vcnt, vlim;
  logic [HW-1:0] hs_q, hb_q, ha_q, hf_q;
  logic [VW-1:0] vs_q, vb_q, va_q, vf_q;
  logic          cmd_q;

  always_comb begin
    case (hph)
      PH_SYNC: hlim = hs_q;
      PH_BACK: hlim = hb_q;
      PH_ACT:  hlim = ha_q;
      default: hlim = hf_q;
    endcase
    case (vph)
      PH_SYNC: vlim = vs_q;
      PH_BACK: vlim = vb_q;
      PH_ACT:  vlim = va_q;
      default: vlim = vf_q;
    endcase
  end

  wire go         = en && !sw_rst;
  wire h_end      = hcnt == hlim;
  wire line_end   = h_end && hph == PH_FRONT;
  wire v_end      = vcnt == vlim;
  wire frame_end  = run && line_end && v_end && vph == PH_FRONT;
  wire load       = go && (!run || frame_end);
  wire into_back  = go && run && line_end && v_end && vph == PH_SYNC;
  wire into_front = go && run && line_end && v_end && vph == PH_ACT;
  wire bump       = (load && !cmd_mode) || (into_back && cmd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      hph   <= PH_SYNC;
      vph   <= PH_SYNC;
      hcnt  <= '0;
      vcnt  <= '0;
      field <= 1'b0;
    end else if (!go) begin
      run   <= 1'b0;
      hph   <= PH_SYNC;
      vph   <= PH_SYNC;
      hcnt  <= '0;
      vcnt  <= '0;
      field <= 1'b0;
    end else if (!run) begin
      run <= 1'b1;
    end else if (!h_end) begin
      hcnt <= hcnt + 1'b1;
    end else begin
      hcnt <= '0;
      hph  <= hph + 2'd1;
      if (hph == PH_FRONT) begin
        if (!v_end) begin
          vcnt <= vcnt + 1'b1;
        end else begin
          vcnt <= '0;
          vph  <= vph + 2'd1;
          if (vph == PH_FRONT) field <= ilace_en ? !field : 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hs_q, hb_q, ha_q, hf_q} <= '0;
      {vs_q, vb_q, va_q, vf_q} <= '0;
      cmd_q <= 1'b0;
    end else if (load) begin
      {hs_q, hb_q, ha_q, hf_q} <= {h_sync_m1, h_back_m1, h_act_m1, h_front_m1};
      {vs_q, vb_q, va_q, vf_q} <= {v_sync_m1, v_back_m1, v_act_m1, v_front_m1};
      cmd_q <= cmd_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_id <= '0;
      frm_irq  <= 1'b0;
      irq_pend <= 1'b0;
    end else if (sw_rst) begin
      frame_id <= '0;
      frm_irq  <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (bump) frame_id <= frame_id + 1'b1;
      frm_irq  <= into_front;
      irq_pend <= into_front || (irq_pend && !irq_clr);
    end
  end

  assign hsync  = run && hph == PH_SYNC;
  assign vsync  = run && vph == PH_SYNC;
  assign de     = run && hph == PH_ACT && vph == PH_ACT;
  assign pix_x  = (run && hph == PH_ACT) ? hcnt : '0;
  assign pix_y  = (run && vph == PH_ACT) ? vcnt : '0;
  assign vphase = vph;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |-> (!hsync && !vsync && !de && vphase == PH_SYNC)); // R1

  AST_VPHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && vph != $past(vph)) |-> (vph == $past(vph) + 2'd1)); // R3

  AST_FID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_rst) |=> (frame_id == $past(frame_id) || frame_id == $past(frame_id) + 1'b1)); // R8

  AST_FID_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cmd_q && frame_id != $past(frame_id)) |-> ($rose(vsync) && hsync)); // R6

  AST_FID_AT_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd_q && frame_id != $past(frame_id)) |-> (vphase == PH_BACK && hsync)); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_irq |=> !frm_irq); // R9

  AST_IRQ_AT_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
    frm_irq |-> (vphase == PH_FRONT && hsync && irq_pend)); // R9

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr && !sw_rst) |=> irq_pend); // R9

  AST_DE_COORD: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && pix_y == $past(pix_y)) |-> (pix_x == $past(pix_x) + 1'b1)); // R4

endmodule

// File: tb/test_video_scan_timer.sv
module test_video_scan_timer;
  localparam int HW = 12;
  localparam int VW = 12;
  localparam int FW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, sw_rst = 1'b0, en = 1'b0, cmd_mode = 1'b0, ilace_en = 1'b0, irq_clr = 1'b0;
  logic [HW-1:0] h_sync_m1 = '0, h_back_m1 = '0, h_act_m1 = '0, h_front_m1 = '0;
  logic [VW-1:0] v_sync_m1 = '0, v_back_m1 = '0, v_act_m1 = '0, v_front_m1 = '0;
  logic hsync, vsync, de, field, frm_irq, irq_pend;
  logic [HW-1:0] pix_x;
  logic [VW-1:0] pix_y;
  logic [1:0] vphase;
  logic [FW-1:0] frame_id;

  video_scan_timer #(.HW(HW), .VW(VW), .FW(FW)) i_video_scan_timer (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .en(en), .cmd_mode(cmd_mode),
    .ilace_en(ilace_en), .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1),
    .h_act_m1(h_act_m1), .h_front_m1(h_front_m1), .v_sync_m1(v_sync_m1),
    .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
    .irq_clr(irq_clr), .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x),
    .pix_y(pix_y), .vphase(vphase), .field(field), .frame_id(frame_id),
    .frm_irq(frm_irq), .irq_pend(irq_pend));

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  string fid_tag = "R6";

  // reference state: position in frame and the counts captured at frame start
  int m_run, m_p, m_fid, m_field, m_pend, m_irq, m_cmd;
  int c_hs, c_hb, c_ha, c_hf, c_vs, c_vb, c_va, c_vf;

  task automatic chk(string req, string name, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, name, act, exp, $time);
    end
  endtask

  task automatic capture();
    c_hs = int'(h_sync_m1) + 1; c_hb = int'(h_back_m1) + 1;
    c_ha = int'(h_act_m1) + 1;  c_hf = int'(h_front_m1) + 1;
    c_vs = int'(v_sync_m1) + 1; c_vb = int'(v_back_m1) + 1;
    c_va = int'(v_act_m1) + 1;  c_vf = int'(v_front_m1) + 1;
    m_cmd = int'(cmd_mode);
  endtask

  task automatic model_edge();
    int len, set;
    len = c_hs + c_hb + c_ha + c_hf;
    set = 0;
    if (!rst_n) begin
      m_run = 0; m_p = 0; m_fid = 0; m_field = 0; m_pend = 0; m_irq = 0;
    end else if (sw_rst) begin
      m_run = 0; m_p = 0; m_fid = 0; m_field = 0; m_pend = 0; m_irq = 0;
    end else begin
      if (!en) begin
        m_run = 0; m_p = 0; m_field = 0;
      end else if (!m_run) begin
        m_run = 1; m_p = 0; capture();
        if (!m_cmd) m_fid++;
      end else begin
        m_p++;
        if (m_p == len * (c_vs + c_vb + c_va + c_vf)) begin
          m_p = 0;
          m_field = ilace_en ? !m_field : 0;
          capture();
          if (!m_cmd) m_fid++;
        end else begin
          if (m_cmd && m_p == c_vs * len) m_fid++;
          if (m_p == (c_vs + c_vb + c_va) * len) set = 1;
        end
      end
      m_irq = set;
      m_pend = set | (m_pend & !irq_clr);
      m_fid = m_fid % (1 << FW);
    end
  endtask

  function automatic int phase_of(int pos, int a, int b, int c);
    if (pos < a) return 0;
    if (pos < a + b) return 1;
    if (pos < a + b + c) return 2;
    return 3;
  endfunction

  task automatic compare(string scen);
    int len, hp, ln, eh, ev;
    len = c_hs + c_hb + c_ha + c_hf;
    hp = m_run ? m_p % len : 0;
    ln = m_run ? m_p / len : 0;
    eh = m_run ? phase_of(hp, c_hs, c_hb, c_ha) : 0;
    ev = m_run ? phase_of(ln, c_vs, c_vb, c_va) : 0;
    chk({scen, " R2"}, "hsync", int'(hsync), int'(m_run != 0 && eh == 0));
    chk({scen, " R3"}, "vsync", int'(vsync), int'(m_run != 0 && ev == 0));
    chk({scen, " R4"}, "de", int'(de), int'(m_run != 0 && eh == 2 && ev == 2));
    chk({scen, " R4"}, "pix_x", int'(pix_x), (m_run != 0 && eh == 2) ? hp - c_hs - c_hb : 0);
    chk({scen, " R4"}, "pix_y", int'(pix_y), (m_run != 0 && ev == 2) ? ln - c_vs - c_vb : 0);
    chk({scen, " R5"}, "vphase", int'(vphase), ev);
    chk({scen, " ", fid_tag}, "frame_id", int'(frame_id), m_fid);
    chk({scen, " R9"}, "frm_irq", int'(frm_irq), m_irq);
    chk({scen, " R9"}, "irq_pend", int'(irq_pend), m_pend);
    chk({scen, " R10"}, "field", int'(field), m_field);
  endtask

  task automatic cyc(string scen);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(scen);
  endtask

  task automatic run_n(string scen, int n);
    for (int i = 0; i < n; i++) cyc(scen);
  endtask

  task automatic set_cfg(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf);
    h_sync_m1 = HW'(hs - 1); h_back_m1 = HW'(hb - 1); h_act_m1 = HW'(ha - 1); h_front_m1 = HW'(hf - 1);
    v_sync_m1 = VW'(vs - 1); v_back_m1 = VW'(vb - 1); v_act_m1 = VW'(va - 1); v_front_m1 = VW'(vf - 1);
  endtask

  // R1: reset and idle state
  task automatic t_reset();
    rst_n = 1'b0;
    run_n("R1", 3);
    rst_n = 1'b1;
    run_n("R1", 3);
    chk("R1", "frame_id after reset", int'(frame_id), 0);
    chk("R1", "irq_pend after reset", int'(irq_pend), 0);
  endtask

  // R2 R3 R4 R5 R6 R9: video mode over two full frames
  task automatic t_video();
    fid_tag = "R6";
    set_cfg(2, 2, 4, 1, 1, 2, 3, 1);
    cmd_mode = 1'b0;
    en = 1'b1;
    run_n("R6", 1);
    chk("R6", "frame_id at first vsync", int'(frame_id), 1);
    chk("R3", "first cycle hsync&vsync", int'(hsync && vsync), 1);
    run_n("R2", 140);
  endtask

  // R9: pending flag holds until cleared, then sets again at next front porch
  task automatic t_irq_clear();
    while (!m_pend) cyc("R9");
    run_n("R9", 4);
    chk("R9", "pend held", int'(irq_pend), 1);
    irq_clr = 1'b1;
    cyc("R9");
    irq_clr = 1'b0;
    chk("R9", "pend cleared", int'(irq_pend), 0);
    while (!m_irq) cyc("R9");
    chk("R9", "pend set again", int'(irq_pend), 1);
  endtask

  // R11: mid-frame rewrite only applies from next frame
  task automatic t_midframe();
    run_n("R11", 20);
    set_cfg(1, 1, 6, 2, 2, 1, 2, 2);
    run_n("R11", 200);
  endtask

  // R12: enable drop stops scan; restart at frame start
  task automatic t_enable_drop();
    run_n("R12", 17);
    en = 1'b0;
    cyc("R12");
    chk("R12", "stopped hsync|vsync", int'(hsync || vsync), 0);
    run_n("R12", 4);
    en = 1'b1;
    cyc("R12");
    chk("R12", "restart at frame start", int'(hsync && vsync && vphase == 2'd0), 1);
    run_n("R12", 70);
  endtask

  // R7: command mode, counter advances at back porch; R8 software reset
  task automatic t_cmd();
    sw_rst = 1'b1;
    cyc("R8");
    sw_rst = 1'b0;
    chk("R8", "frame_id after sw_rst", int'(frame_id), 0);
    chk("R8", "irq_pend after sw_rst", int'(irq_pend), 0);
    fid_tag = "R7";
    set_cfg(2, 2, 4, 1, 1, 2, 3, 1);
    cmd_mode = 1'b1;
    cyc("R7");
    chk("R7", "no increment at vsync", int'(frame_id), 0);
    run_n("R7", 9);
    chk("R7", "increment at back porch", int'(frame_id), 1);
    run_n("R7", 130);
    cmd_mode = 1'b0;
    fid_tag = "R6";
  endtask

  // R10: interlace field toggles per field
  task automatic t_ilace();
    int f0;
    ilace_en = 1'b1;
    run_n("R10", 130);
    f0 = int'(field);
    run_n("R10", 63);
    chk("R10", "field toggled", int'(field), 1 - f0);
    ilace_en = 1'b0;
    run_n("R10", 70);
    chk("R10", "field cleared", int'(field), 0);
  endtask

  // R8: counter wraps modulo 2^FW and never steps back
  task automatic t_wrap();
    bit wrapped = 1'b0;
    int prev;
    fid_tag = "R8";
    prev = int'(frame_id);
    for (int i = 0; i < 20 * 63; i++) begin
      cyc("R8");
      if (int'(frame_id) == 0 && prev == (1 << FW) - 1) wrapped = 1'b1;
      prev = int'(frame_id);
    end
    chk("R8", "wrap observed", int'(wrapped), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_run = 0; m_p = 0; m_fid = 0; m_field = 0; m_pend = 0; m_irq = 0; m_cmd = 0;
    c_hs = 1; c_hb = 1; c_ha = 1; c_hf = 1; c_vs = 1; c_vb = 1; c_va = 1; c_vf = 1;
    @(negedge clk);
    t_reset();
    t_video();
    t_irq_clear();
    t_midframe();
    t_enable_drop();
    t_cmd();
    t_ilace();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule